// File: doc/BRIEF.md
# Multicart Bank Mapper with Pad-Selected Open-Bus Gate

This block sits between an 8-bit console CPU bus and the program and pattern ROMs of a multi-game cartridge. CPU writes are decoded into three byte registers: a program control register and a pattern control register, both written in the $6000-$7FFF window, and an inner data latch, written anywhere in $8000-$FFFF. From these it forms the program ROM address for the $8000-$FFFF window, an 8 KB pattern bank number and the nametable mirroring select. Games run in 16 KB or 32 KB program mode. The pattern bank can take 0, 1 or 2 of its low bits from the inner latch. The number of latch bits is chosen at run time.

Setting the lock bit of the program register seals both control registers until a soft reset. The inner latch stays writable while sealed. A two-bit pad setting steps through three values on each soft reset. It is compared with two bits of the pattern register to decide whether a ROM read is driven or left floating. The menu program uses this to find out which pad setting is fitted.

The block contains two small state machines. The lock machine has the states LK_OPEN and LK_SEALED. It moves from LK_OPEN to LK_SEALED on a program-register write with data bit 5 set, and it returns to LK_OPEN on a soft reset. The pad machine has the states PAD_S0, PAD_S1 and PAD_S2. Each soft reset steps it S0→S1→S2→S0. It holds its state otherwise. PAD_S0 gives pad bits 00, PAD_S1 gives 01 and PAD_S2 gives 10.

Top module: `mcart_mapper`

## Requirements
- R1: A write with address bits 15:13 = 011 loads the program register when address bit 0 is 0, and the pattern register when it is 1. Writes below $6000 change no register.
- R2: While the lock bit (program register bit 5) is set, writes in $6000-$7FFF change neither control register.
- R3: Any write with address bit 15 set loads the whole data byte into the inner latch, locked or not, and changes neither control register.
- R4: The program bank number is {P[6], P[2:0]}, where P is the program register. When P[3] = 1, prg_addr = {bank, cpu_addr[13:0]} for both 16 KB halves.
- R5: When P[3] = 0, prg_addr = {bank[3:1], cpu_addr[14], cpu_addr[13:0]}. This selects the 32 KB bank bank>>1.
- R6: The outer pattern bank is {P[6], C[2:0]}, where C is the pattern register. The mask m is 0 when C[4] = 1, 1 when C[5:4] = 10, and 3 when C[5:4] = 00. chr_bank = (outer & ~m) | (latch & m).
- R7: mirror_sel equals the inverse of P[4].
- R8: rom_oe is 1 only when cpu_rd = 1, cpu_addr[15] = 1 and (C[7:6] & pad bits) = 0.
- R9: A soft reset clears the program register, the pattern register and the latch, and returns the lock to LK_OPEN. It takes priority over a write in the same cycle.
- R10: Each soft reset advances the pad state S0→S1→S2→S0. With no soft reset the pad state holds.
- R11: After power-on reset (rst_n low), all registers and the pad state are 0, so that prg_addr = {3'b000, cpu_addr[14:0]}, chr_bank = 0 and mirror_sel = 1.
- R12: A register write takes effect on the clock edge where cpu_wr is high. The outputs are combinational from the registers and the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| soft_rst | input | 1 | Synchronous soft-reset pulse |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe |
| prg_addr | output | 18 | Program ROM byte address |
| chr_bank | output | 4 | 8 KB pattern bank number |
| rom_oe | output | 1 | Program ROM output enable (0 = open bus) |
| mirror_sel | output | 1 | Nametable mirroring select |

## Verification
The assertions assume three things about the inputs:
- cpu_wr is a single-cycle strobe.
- soft_rst is a synchronous pulse that is never asserted during power-on reset.
- The address and data are stable across the edge where the strobe is sampled.

The bench keeps to these. All inputs change only on falling edges, each write lasts exactly one cycle, and soft resets are issued only after rst_n has been released. Outputs are checked half a cycle after the edge that takes the write. Expected values come from an arithmetic model of the register fields.

// File: rtl/mcart_pkg.sv
package mcart_pkg;
    parameter int ADDR_W  = 16;
    parameter int DATA_W  = 8;
    parameter int BANK_W  = 4;
    parameter int OFS_W   = 14;
    parameter int CHR_W   = 4;
    parameter int PAD_W   = 2;
    parameter int LOCK_BIT = 5;
    localparam int PRG_AW = BANK_W + OFS_W;

    typedef enum logic {LK_OPEN, LK_SEALED} lock_state_t;
    typedef enum logic [1:0] {PAD_S0 = 2'd0, PAD_S1 = 2'd1, PAD_S2 = 2'd2} pad_state_t;
endpackage

// File: rtl/mcart_regfile.sv
module mcart_regfile
    import mcart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_wr,
    output logic [DATA_W-1:0] preg_q,
    output logic [DATA_W-1:0] creg_q,
    output logic [DATA_W-1:0] latch_q
);
    lock_state_t lk_q, lk_d;
    logic in_ctl, in_rom, ctl_we;

    assign in_ctl = (cpu_addr[ADDR_W-1 -: 3] == 3'b011);
    assign in_rom = cpu_addr[ADDR_W-1];
    assign ctl_we = cpu_wr && in_ctl && (lk_q == LK_OPEN) && !soft_rst;

    // lock machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= LK_OPEN;
        else        lk_q <= lk_d;
    end

    // lock machine: next state
    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_OPEN:   if (ctl_we && !cpu_addr[0] && cpu_data[LOCK_BIT]) lk_d = LK_SEALED;
            LK_SEALED: lk_d = LK_SEALED;
            default:   lk_d = LK_OPEN;
        endcase
        if (soft_rst) lk_d = LK_OPEN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preg_q  <= '0;
            creg_q  <= '0;
            latch_q <= '0;
        end else if (soft_rst) begin
            preg_q  <= '0;
            creg_q  <= '0;
            latch_q <= '0;
        end else begin
            if (ctl_we && !cpu_addr[0]) preg_q <= cpu_data;
            if (ctl_we &&  cpu_addr[0]) creg_q <= cpu_data;
            if (cpu_wr && in_rom)       latch_q <= cpu_data;
        end
    end

    // R2: sealed registers ignore control-window writes
    a_r2_sealed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q == LK_SEALED && cpu_wr && in_ctl && !soft_rst) |=> ($stable(preg_q) && $stable(creg_q)));

    // R3: latch loads the full byte regardless of the lock
    a_r3_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && in_rom && !soft_rst) |=> (latch_q == $past(cpu_data)));

    // R9: soft reset clears everything and unseals
    a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (preg_q == '0 && creg_q == '0 && latch_q == '0 && lk_q == LK_OPEN));
endmodule

// File: rtl/mcart_padseq.sv
module mcart_padseq
    import mcart_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    output logic [PAD_W-1:0] pad_bits
);
    pad_state_t pad_q, pad_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pad_q <= PAD_S0;
        else        pad_q <= pad_d;
    end

    always_comb begin
        pad_d = pad_q;
        if (soft_rst) begin
            unique case (pad_q)
                PAD_S0:  pad_d = PAD_S1;
                PAD_S1:  pad_d = PAD_S2;
                PAD_S2:  pad_d = PAD_S0;
                default: pad_d = PAD_S0;
            endcase
        end
    end

    always_comb begin
        unique case (pad_q)
            PAD_S0:  pad_bits = 2'b00;
            PAD_S1:  pad_bits = 2'b01;
            PAD_S2:  pad_bits = 2'b10;
            default: pad_bits = 2'b00;
        endcase
    end

    // R10: stepping order and hold
    a_r10_step_s0: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && pad_q == PAD_S0) |=> (pad_q == PAD_S1));
    a_r10_wrap_s2: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && pad_q == PAD_S2) |=> (pad_q == PAD_S0));
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> $stable(pad_q));
endmodule

// File: rtl/mcart_xlate.sv
module mcart_xlate
    import mcart_pkg::*;
(
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] preg_q,
    input  logic [DATA_W-1:0] creg_q,
    input  logic [DATA_W-1:0] latch_q,
    input  logic [PAD_W-1:0]  pad_bits,
    output logic [PRG_AW-1:0] prg_addr,
    output logic [CHR_W-1:0]  chr_bank,
    output logic              rom_oe,
    output logic              mirror_sel
);
    logic [BANK_W-1:0] prg_bank, bank16;
    logic [CHR_W-1:0]  outer, mask;
    logic              blocked;
    logic              unused_bits;

    assign prg_bank = {preg_q[6], preg_q[2:0]};
    assign bank16   = preg_q[3] ? prg_bank : {prg_bank[BANK_W-1:1], cpu_addr[OFS_W]};
    assign prg_addr = {bank16, cpu_addr[OFS_W-1:0]};

    assign outer = {preg_q[6], creg_q[2:0]};
    always_comb begin
        unique casez (creg_q[5:4])
            2'b?1:   mask = 4'b0000;
            2'b10:   mask = 4'b0001;
            default: mask = 4'b0011;
        endcase
    end
    assign chr_bank = (outer & ~mask) | (latch_q[CHR_W-1:0] & mask);

    assign mirror_sel = ~preg_q[4];
    assign blocked    = |(creg_q[7:6] & pad_bits);
    assign rom_oe     = cpu_rd && cpu_addr[ADDR_W-1] && !blocked;

    assign unused_bits = ^{preg_q[7], preg_q[5], creg_q[3], latch_q[DATA_W-1:CHR_W]};
endmodule

// File: rtl/mcart_mapper.sv
module mcart_mapper
    import mcart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [PRG_AW-1:0] prg_addr,
    output logic [CHR_W-1:0]  chr_bank,
    output logic              rom_oe,
    output logic              mirror_sel
);
    logic [DATA_W-1:0] preg_q, creg_q, latch_q;
    logic [PAD_W-1:0]  pad_bits;

    mcart_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
        .preg_q(preg_q), .creg_q(creg_q), .latch_q(latch_q)
    );

    mcart_padseq u_pad (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pad_bits(pad_bits)
    );

    mcart_xlate u_xlate (
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .preg_q(preg_q), .creg_q(creg_q), .latch_q(latch_q), .pad_bits(pad_bits),
        .prg_addr(prg_addr), .chr_bank(chr_bank), .rom_oe(rom_oe), .mirror_sel(mirror_sel)
    );

    // R8: the ROM is never driven outside a read of the upper half
    a_r8_oe_window: assert property (@(posedge clk) disable iff (!rst_n)
        rom_oe |-> (cpu_rd && cpu_addr[ADDR_W-1]));
endmodule

// File: tb/sim_mcart_mapper.sv
module sim_mcart_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [17:0] prg_addr;
    logic [3:0]  chr_bank;
    logic        rom_oe, mirror_sel;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int m_p = 0, m_c = 0, m_l = 0, m_pad = 0;

    always #4 clk = ~clk;

    mcart_mapper u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .prg_addr(prg_addr),
        .chr_bank(chr_bank), .rom_oe(rom_oe), .mirror_sel(mirror_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cpu_addr = a[15:0];
        cpu_data = d[7:0];
        cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic pulse_soft();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        m_p = 0; m_c = 0; m_l = 0;
        m_pad = (m_pad + 1) % 3;
    endtask

    function automatic int exp_prg(input int p, input int a);
        int bank = ((p >> 6) & 1) * 8 + (p & 7);
        int b16 = ((p >> 3) & 1) ? bank : ((bank & 14) | ((a >> 14) & 1));
        return b16 * 16384 + (a & 16'h3FFF);
    endfunction

    function automatic int exp_chr(input int p, input int c, input int l);
        int outer = ((p >> 6) & 1) * 8 + (c & 7);
        int m = ((c >> 4) & 1) ? 0 : (((c >> 5) & 1) ? 1 : 3);
        return (outer & ~m & 15) | (l & m);
    endfunction

    function automatic int exp_oe(input int c, input int pad, input int a);
        int padbits = (pad == 0) ? 0 : ((pad == 1) ? 1 : 2);
        return (((a >> 15) & 1) && ((((c >> 6) & 3) & padbits) == 0)) ? 1 : 0;
    endfunction

    task automatic check_all(input string req);
        for (int a14 = 0; a14 < 2; a14++) begin
            cpu_addr = 16'h8000 | 16'(a14 << 14) | 16'h0A5C;
            #1;
            chk(req, int'(prg_addr), exp_prg(m_p, int'(cpu_addr)));
        end
        chk(req, int'(chr_bank), exp_chr(m_p, m_c, m_l));
        chk(req, int'(mirror_sel), ((m_p >> 4) & 1) ^ 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 power-on state
        cpu_rd = 1'b1;
        check_all("R11");
        chk("R11", int'(rom_oe), 1);

        // R1 R4 R5 R7 R12: sweep program register (lock bit clear), vary window address
        for (int v = 0; v < 128; v++) begin
            if ((v & 32) != 0) continue;
            wr(16'h6000 | ((v * 2) & 16'h1FFE), v);
            m_p = v;
            check_all("R4/R5/R7 prog sweep R1");
        end

        // R6: pattern banking sweep with both values of P[6]
        for (int ph = 0; ph < 2; ph++) begin
            wr(16'h7FFE, ph * 64);
            m_p = ph * 64;
            for (int c = 0; c < 64; c++) begin
                wr(16'h6001 | ((c * 2) & 16'h1FFE), c);
                m_c = c;
                for (int l = 0; l < 4; l++) begin
                    wr(16'h8000 | (l * 16'h1111), 8'hFC | l);
                    m_l = 8'hFC | l;
                    @(negedge clk);
                    chk("R6 chr mask", int'(chr_bank), exp_chr(m_p, m_c, m_l));
                end
            end
        end

        // R1: writes below $6000 are ignored
        wr(16'h6000, 8'h0D); m_p = 8'h0D;
        wr(16'h6001, 8'h00); m_c = 0;
        wr(16'h4000, 8'h5A);
        wr(16'h5FFF, 8'h77);
        check_all("R1 ignored low write");
        // R3: latch write does not touch control registers
        wr(16'hE000, 8'h02); m_l = 2;
        check_all("R3 latch only");

        // R2: lock, then control writes ignored; R3 latch still writable
        wr(16'h6000, 8'h2B); m_p = 8'h2B;
        check_all("R2 lock write");
        wr(16'h6000, 8'h00);
        wr(16'h7FFF, 8'h17);
        check_all("R2 sealed");
        wr(16'hC000, 8'h01); m_l = 1;
        check_all("R3 latch while sealed");

        // R9: soft reset clears and unseals
        pulse_soft();
        check_all("R9 soft clear");
        wr(16'h6000, 8'h09); m_p = 9;
        check_all("R9 unsealed");

        // R8 R10: read gate over pad states, wrapping back to S0
        for (int r = 0; r < 4; r++) begin
            for (int cc = 0; cc < 4; cc++) begin
                wr(16'h6001, cc * 64);
                m_c = cc * 64;
                for (int hi = 0; hi < 2; hi++) begin
                    cpu_addr = hi ? 16'hB123 : 16'h7123;
                    cpu_rd = 1'b1;
                    #1;
                    chk("R8/R10 rom_oe", int'(rom_oe), exp_oe(m_c, m_pad, int'(cpu_addr)));
                    cpu_rd = 1'b0;
                    #1;
                    chk("R8 no read", int'(rom_oe), 0);
                end
            end
            pulse_soft();
            check_all("R9 after soft");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule